// File: doc/BRIEF.md
# Memory-Mapped Character Display Bridge

This block lets a processor with a plain external data bus drive a parallel character display module. The display is reached through ordinary external-memory reads and writes, so no port pins or bit-banging are needed. Four consecutive addresses starting at a 4-aligned base are decoded. The two low address bits go straight to the module's register-select and read/write lines. This lays the command register, the status register and the two data ports over the window.

The processor strobe is short. The display needs a long enable pulse, with select and direction lines that settle before enable rises and stay unchanged until after it falls. The bridge therefore runs a three-phase sequence from each accepted strobe: setup, enable pulse and hold. The length of each phase is a parameter, counted in clock cycles. While the sequence runs, a wait output asks the bus master to stretch its cycle. On a write, the bridge latches the bus byte when the strobe arrives and drives it to the module. On a read, it captures the module's data at the end of the pulse and returns it to the bus until the read strobe is released.

Top module: `lcdb_bridge`

## Requirements
- R1: After reset: `lcd_e` is 0, `lcd_rw` is 1 (read), `lcd_rs` is 0, `lcd_dout_oe` is 0, `bus_rdata_oe` is 0 and `bus_wait` is 0.
- R2: Only a strobe whose address lies in BASE..BASE+3 (default 0xFE00..0xFE03) starts a transaction. Any other address gives no enable pulse and no wait.
- R3: During a transaction, `lcd_rs` equals address bit 1 and `lcd_rw` equals address bit 0 (1 = read). So base+0 is a command write, base+1 a status read, base+2 a data write and base+3 a data read.
- R4: A write strobe to an odd address, or a read strobe to an even address, is ignored: no enable pulse, no wait, no read data driven.
- R5: `lcd_rs` and `lcd_rw` are valid for SETUP_CYC cycles before `lcd_e` rises. They stay unchanged while `lcd_e` is high and for HOLD_CYC cycles after it falls.
- R6: `lcd_e` is high for exactly PULSE_CYC consecutive cycles per transaction.
- R7: `bus_wait` rises on the clock edge that samples an accepted strobe rising. It stays high for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles, which covers the whole setup, pulse and hold, and `lcd_e` is never high without it.
- R8: A strobe that rises while a transaction is in progress is ignored. A strobe still held high when the transaction ends does not start another one.
- R9: On a write, the bus byte present when the strobe is accepted is driven on `lcd_dout` with `lcd_dout_oe` high through the enable pulse and the hold. Later changes to `bus_wdata` have no effect.
- R10: On a read, `lcd_din` is sampled at the clock edge that ends the enable pulse. The captured byte is driven on `bus_rdata` with `bus_rdata_oe` high until the read strobe is deasserted, and `bus_rdata_oe` is low at all other times.
- R11: `lcd_dout_oe` is never high while `lcd_rw` is 1 or while `bus_rdata_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 16 | Processor external address |
| bus_wdata | input | 8 | Processor write data |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_rdata | output | 8 | Read data returned to the processor |
| bus_rdata_oe | output | 1 | Drive enable for `bus_rdata` |
| bus_wait | output | 1 | Cycle-extension request to the bus master |
| lcd_e | output | 1 | Display enable, active high |
| lcd_rs | output | 1 | Display register select (0 command/status, 1 data) |
| lcd_rw | output | 1 | Display direction (1 read, 0 write) |
| lcd_dout | output | 8 | Data toward the display |
| lcd_dout_oe | output | 1 | Drive enable for `lcd_dout` |
| lcd_din | input | 8 | Data from the display |

## Verification
Assertions check four properties on every cycle, whatever the traffic:
- select and direction stay stable while enable is high and on the cycle it falls,
- enable never exceeds the pulse width and falls at exactly that width,
- enable never appears without wait,
- the two data drivers never contend, and the write driver only drives when direction is write.

Some behaviour only the bench scenarios can show:
- the address-bit mapping of each of the four registers,
- the rejection of out-of-window and wrong-direction strobes,
- that a strobe arriving during a busy transaction is dropped,
- that the write byte is latched despite later bus changes,
- that the read byte is the one present in the last pulse cycle and not earlier.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_PULSE = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  // Kind of access, taken from the low address bits at acceptance.
  typedef struct packed {
    logic sel_data;  // address bit 1: 0 command/status, 1 data
    logic is_read;   // address bit 0: 1 read
  } acc_kind_t;

endpackage

// File: rtl/lcdb_decode.sv
module lcdb_decode
  import lcdb_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              seq_idle,
  output logic              start,
  output acc_kind_t         start_kind
);

  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  logic wr_q, rd_q;
  logic wr_rise, rd_rise;
  logic in_window;
  logic legal_wr, legal_rd;

  // Strobe history for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= bus_wr;
      rd_q <= bus_rd;
    end
  end

  always_comb begin
    wr_rise   = bus_wr & ~wr_q;
    rd_rise   = bus_rd & ~rd_q;
    in_window = (bus_addr[ADDR_W-1:2] == BASE_W[ADDR_W-1:2]);
    // Direction must agree with address bit 0
    legal_wr  = wr_rise & in_window & ~bus_addr[0];
    legal_rd  = rd_rise & in_window &  bus_addr[0];
    start     = seq_idle & (legal_wr | legal_rd);
    start_kind.sel_data = bus_addr[1];
    start_kind.is_read  = bus_addr[0];
  end

  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (bus_addr[ADDR_W-1:2] == BASE_W[ADDR_W-1:2])) else $error("start outside window"); // R2

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (wr_q | rd_q)) else $error("start without strobe"); // R8

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  acc_kind_t start_kind,
  output logic      seq_idle,
  output logic      capture,
  output logic      busy,
  output logic      lcd_e,
  output logic      lcd_rs,
  output logic      lcd_rw,
  output logic      wr_drive
);

  localparam int CNT_MAX = (SETUP_CYC > PULSE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W  = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);
  localparam int RUN_W  = CNT_W + 1;
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [RUN_W-1:0] PULSE_RW = RUN_W'(PULSE_CYC);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  acc_kind_t         kind_q, kind_d;
  logic              cnt_zero;
  logic              e_d, rs_d, rw_d, busy_d, drv_d;
  logic              e_q, rs_q, rw_q, busy_q, drv_q;
  logic              kind_en;

  assign cnt_zero = (cnt_q == '0);
  assign kind_en  = start & (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          state_d = ST_PULSE;
          cnt_d   = LD_PULSE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt_zero) begin
          state_d = ST_HOLD;
          cnt_d   = LD_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_comb begin
    kind_d = kind_en ? start_kind : kind_q;
    busy_d = (state_d != ST_IDLE);
    e_d    = (state_d == ST_PULSE);
    rs_d   = busy_d ? kind_d.sel_data : 1'b0;
    rw_d   = busy_d ? kind_d.is_read  : 1'b1;
    drv_d  = busy_d & ~kind_d.is_read;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
    end else if (kind_en) begin
      kind_q <= start_kind;
    end
  end

  // Output registers: pins toggle only from flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q    <= 1'b0;
      rs_q   <= 1'b0;
      rw_q   <= 1'b1;
      busy_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      e_q    <= e_d;
      rs_q   <= rs_d;
      rw_q   <= rw_d;
      busy_q <= busy_d;
      drv_q  <= drv_d;
    end
  end

  assign seq_idle = (state_q == ST_IDLE);
  assign capture  = (state_q == ST_PULSE) & cnt_zero;
  assign busy     = busy_q;
  assign lcd_e    = e_q;
  assign lcd_rs   = rs_q;
  assign lcd_rw   = rw_q;
  assign wr_drive = drv_q;

  // Enable run-length counter used only by the checks below
  logic [RUN_W-1:0] e_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   e_run_q <= '0;
    else if (e_q) e_run_q <= e_run_q + 1'b1;
    else          e_run_q <= '0;
  end

  AST_SEL_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (e_q && $past(e_q)) |-> ($stable(rs_q) && $stable(rw_q))) else $error("select moved during enable"); // R5

  AST_SEL_STABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_q) |-> (busy_q && $stable(rs_q) && $stable(rw_q))) else $error("select moved at enable fall"); // R5

  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_q) |-> ($past(busy_q) && $stable(rs_q) && $stable(rw_q))) else $error("enable rose without setup"); // R5

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> (e_run_q < PULSE_RW)) else $error("enable too long"); // R6

  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_q) |-> (e_run_q == PULSE_RW)) else $error("enable width wrong"); // R6

  AST_E_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> busy_q) else $error("enable without wait"); // R7

endmodule

// File: rtl/lcdb_data.sv
module lcdb_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              capture,
  input  logic              lcd_rw,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] lcd_din,
  input  logic              wr_drive,
  output logic [DATA_W-1:0] lcd_dout,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe
);

  logic [DATA_W-1:0] wbuf_q;
  logic [DATA_W-1:0] rbuf_q;
  logic              roe_q, roe_d;
  logic              rcap_en;

  assign rcap_en = capture & lcd_rw;

  // Write byte latched on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wbuf_q <= '0;
    else if (load_wr) wbuf_q <= bus_wdata;
  end

  // Display byte captured in the last enable cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbuf_q <= '0;
    else if (rcap_en) rbuf_q <= lcd_din;
  end

  always_comb begin
    roe_d = roe_q;
    if (!bus_rd)      roe_d = 1'b0;
    else if (rcap_en) roe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) roe_q <= 1'b0;
    else        roe_q <= roe_d;
  end

  assign lcd_dout     = wbuf_q;
  assign bus_rdata    = rbuf_q;
  assign bus_rdata_oe = roe_q;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(roe_q && wr_drive)) else $error("both drivers on"); // R11

  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drive |-> !lcd_rw) else $error("write driver on during read"); // R11

  AST_WBYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drive && $past(wr_drive)) |-> $stable(lcd_dout)) else $error("write byte changed"); // R9

  AST_ROE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    roe_q |-> $past(bus_rd)) else $error("read data driven without strobe"); // R10

endmodule

// File: rtl/lcdb_bridge.sv
module lcdb_bridge
  import lcdb_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] BASE_ADDR = 16'hFE00,
  parameter int          SETUP_CYC = 2,
  parameter int          PULSE_CYC = 4,
  parameter int          HOLD_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_wait,
  output logic              lcd_e,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic [DATA_W-1:0] lcd_dout,
  output logic              lcd_dout_oe,
  input  logic [DATA_W-1:0] lcd_din
);

  logic      seq_idle;
  logic      start;
  acc_kind_t start_kind;
  logic      capture;
  logic      wr_drive;
  logic      load_wr;

  lcdb_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .seq_idle   (seq_idle),
    .start      (start),
    .start_kind (start_kind)
  );

  lcdb_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (start_kind),
    .seq_idle   (seq_idle),
    .capture    (capture),
    .busy       (bus_wait),
    .lcd_e      (lcd_e),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .wr_drive   (wr_drive)
  );

  assign load_wr = start & ~start_kind.is_read;

  lcdb_data #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_wr      (load_wr),
    .bus_wdata    (bus_wdata),
    .capture      (capture),
    .lcd_rw       (lcd_rw),
    .bus_rd       (bus_rd),
    .lcd_din      (lcd_din),
    .wr_drive     (wr_drive),
    .lcd_dout     (lcd_dout),
    .bus_rdata    (bus_rdata),
    .bus_rdata_oe (bus_rdata_oe)
  );

  assign lcd_dout_oe = wr_drive;

  AST_WAIT_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bus_wait) else $error("wait missing after start"); // R7

  AST_RS_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (lcd_rs == $past(bus_addr[1]) && lcd_rw == $past(bus_addr[0]))) else $error("select mapping"); // R3

endmodule

// File: tb/sim_lcdb_bridge.sv
`timescale 1ns/1ps
module sim_lcdb_bridge;

  localparam int          S    = 2;
  localparam int          P    = 4;
  localparam int          H    = 2;
  localparam logic [15:0] BASE = 16'hFE00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe, bus_wait;
  logic        lcd_e, lcd_rs, lcd_rw, lcd_dout_oe;
  logic [7:0]  lcd_dout;
  logic [7:0]  lcd_din;

  always #2 clk = ~clk;

  lcdb_bridge #(
    .BASE_ADDR (BASE), .SETUP_CYC (S), .PULSE_CYC (P), .HOLD_CYC (H)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
    .bus_rdata_oe (bus_rdata_oe), .bus_wait (bus_wait), .lcd_e (lcd_e),
    .lcd_rs (lcd_rs), .lcd_rw (lcd_rw), .lcd_dout (lcd_dout),
    .lcd_dout_oe (lcd_dout_oe), .lcd_din (lcd_din)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic       rs;
    logic       rw;
    logic [7:0] data;
  } exp_t;
  exp_t sbq[$];

  // Display model value returned in the final pulse cycle
  logic [7:0] model_val = 8'h00;
  int pulses = 0;

  // Monitor: pops expected accesses and checks timing at the pins
  bit         e_prev  = 0;
  bit         in_hold = 0;
  int         pre_cnt = 0, high_cnt = 0, hold_cnt = 0;
  logic       rs_seen, rw_seen;
  always @(negedge clk) begin
    if (!rst_n) begin
      e_prev = 0; in_hold = 0; pre_cnt = 0; high_cnt = 0; hold_cnt = 0;
      lcd_din = 8'h5A;
    end else begin
      if (bus_wait && !lcd_e && !e_prev && !in_hold) pre_cnt++;
      if (lcd_e && !e_prev) begin
        exp_t e;
        pulses++;
        chk("R5", "setup cycles", pre_cnt, S);
        chk("R7", "wait with enable", bus_wait, 1);
        rs_seen = lcd_rs; rw_seen = lcd_rw;
        if (sbq.size() == 0) begin
          chk("R2", "unexpected enable pulse", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk("R3", "register select", lcd_rs, e.rs);
          chk("R3", "direction", lcd_rw, e.rw);
          if (!e.rw) begin
            chk("R9", "write drive", lcd_dout_oe, 1);
            chk("R9", "write byte", lcd_dout, e.data);
          end else begin
            chk("R11", "no write drive on read", lcd_dout_oe, 0);
          end
          chk("R10", "read data idle during pulse", bus_rdata_oe, 0);
        end
        high_cnt = 1;
      end else if (lcd_e) begin
        high_cnt++;
        if (lcd_rs !== rs_seen || lcd_rw !== rw_seen)
          chk("R5", "select stable in pulse", {lcd_rs, lcd_rw}, {rs_seen, rw_seen});
      end
      if (!lcd_e && e_prev) begin
        chk("R6", "pulse width", high_cnt, P);
        chk("R5", "select held at fall", {lcd_rs, lcd_rw}, {rs_seen, rw_seen});
        if (!rw_seen) chk("R9", "write drive in hold", lcd_dout_oe, 1);
        in_hold = 1; hold_cnt = 0;
      end
      if (in_hold) begin
        if (bus_wait) begin
          hold_cnt++;
        end else begin
          chk("R7", "hold cycles", hold_cnt, H);
          chk("R1", "direction released", lcd_rw, 1);
          chk("R11", "write drive released", lcd_dout_oe, 0);
          in_hold = 0; pre_cnt = 0;
        end
      end
      // Display model: valid byte only in the last pulse cycle
      if (lcd_e && high_cnt == P) lcd_din = model_val;
      else                        lcd_din = ~model_val;
      e_prev = lcd_e;
    end
  end

  // Driver: one bus access, pushes expectation when legal
  task automatic access(input logic [15:0] a, input bit is_wr,
                        input logic [7:0] d, input bit legal, input string req);
    int p0;
    @(negedge clk);
    p0 = pulses;
    bus_addr = a; bus_wdata = d;
    if (is_wr) bus_wr = 1'b1; else bus_rd = 1'b1;
    if (legal) sbq.push_back('{a[1], a[0], d});
    @(negedge clk);
    chk(req, "wait after strobe", bus_wait, legal);
    if (is_wr) bus_wdata = ~d;  // later bus changes must not matter (R9)
    while (bus_wait) @(negedge clk);
    chk(req, "pulse count", pulses - p0, legal ? 1 : 0);
    if (!is_wr) begin
      chk(legal ? "R10" : req, "read data drive", bus_rdata_oe, legal);
      if (legal) chk("R10", "read byte", bus_rdata, model_val);
    end
    repeat (2) @(negedge clk);
    chk("R10", "read drive held until strobe drops", bus_rdata_oe, legal && !is_wr);
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    chk("R10", "read drive off after strobe", bus_rdata_oe, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "enable", lcd_e, 0);
    chk("R1", "direction", lcd_rw, 1);
    chk("R1", "select", lcd_rs, 0);
    chk("R1", "write drive", lcd_dout_oe, 0);
    chk("R1", "read drive", bus_rdata_oe, 0);
    chk("R1", "wait", bus_wait, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: each register of the window
    access(BASE + 16'd0, 1, 8'h38, 1, "R3");
    model_val = 8'h80;
    access(BASE + 16'd1, 0, 8'h00, 1, "R3");
    access(BASE + 16'd2, 1, 8'h41, 1, "R3");
    model_val = 8'hC3;
    access(BASE + 16'd3, 0, 8'h00, 1, "R3");
    access(BASE + 16'd2, 1, 8'hFF, 1, "R9");
    access(BASE + 16'd0, 1, 8'h00, 1, "R9");

    // R2: outside the window
    access(16'hFE04, 1, 8'h11, 0, "R2");
    access(16'hFDFF, 0, 8'h00, 0, "R2");
    access(16'h0002, 1, 8'h22, 0, "R2");

    // R4: direction mismatch
    access(BASE + 16'd1, 1, 8'h33, 0, "R4");
    access(BASE + 16'd3, 1, 8'h44, 0, "R4");
    access(BASE + 16'd0, 0, 8'h00, 0, "R4");
    access(BASE + 16'd2, 0, 8'h00, 0, "R4");

    // R8: a read strobe rising during a write is dropped
    begin
      int p0;
      @(negedge clk);
      p0 = pulses;
      bus_addr = BASE + 16'd2; bus_wdata = 8'h5E; bus_wr = 1'b1;
      sbq.push_back('{1'b1, 1'b0, 8'h5E});
      @(negedge clk);
      @(negedge clk);
      bus_addr = BASE + 16'd3; bus_rd = 1'b1;
      while (bus_wait) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R8", "single pulse with overlapping strobe", pulses - p0, 1);
      chk("R8", "no read data", bus_rdata_oe, 0);
      chk("R8", "no retrigger from held strobe", bus_wait, 0);
      bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (2) @(negedge clk);
    end

    // Back-to-back reads with a new display value
    model_val = 8'h1F;
    access(BASE + 16'd3, 0, 8'h00, 1, "R10");
    model_val = 8'hE0;
    access(BASE + 16'd1, 0, 8'h00, 1, "R10");

    repeat (4) @(negedge clk);
    chk("R2", "scoreboard drained", sbq.size(), 0);
    finish_run();
  end

endmodule